// File: doc/BRIEF.md
# Coherence Directory Home Controller

This block is the home side of a directory coherence scheme for a small shared-memory system with a fixed set of nodes. For every memory line it owns, it keeps a line state (Invalid, Shared or Exclusive), a bit vector of the nodes holding a copy, and an owner index that is meaningful only while the line is Exclusive. It also holds the home copy of each line's data in a small internal array.

Nodes send read or exclusive-read requests on a valid/ready request channel. Depending on the directory entry, the controller does one of three things. It can answer from its own memory on the response channel. It can redirect the request on the forward channel to the node that owns the line exclusively, and that owner answers the requester directly. It can send invalidations to the other holders and then grant ownership. The exclusive grant does not wait for any invalidation acknowledgement. After a forwarded read, the former owner returns the line's data on a write-back channel, and the home memory takes that data.

Every outgoing channel follows the valid/ready rules. Once valid is raised, the payload stays unchanged until ready is seen on a clock edge. A receiver may hold ready low for any number of cycles. The request channel accepts one transaction at a time. Its ready stays low from acceptance until the last response, forward or write-back of that transaction completes.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid, fwd_valid and wb_ready are 0. Every line is Invalid with no holders, and every line's home data reads as zero.
- R2: A read (req_excl=0) to a line that is not Exclusive produces one response to the requester with the line's home data and rsp_excl=0, and no forward. The requester is added to the line's holders and the line becomes Shared.
- R3: A read to a line held Exclusive by another node produces no response. Instead it sends one forward with fwd_kind=0 (read) to the owner, carrying the requester id in fwd_req. The controller then raises wb_ready until one write-back is taken, and that data becomes the line's home data. The line becomes Shared, with both the former owner and the requester as holders.
- R4: An exclusive request (req_excl=1) to a line that is not Exclusive sends one forward with fwd_kind=1 (invalidate) to each other holder, lowest node index first. It then sends one response to the requester with the home data and rsp_excl=1. The requester becomes the sole holder and owner.
- R5: No forward is ever addressed to the requester of the current transaction. If no other node holds the line, the exclusive grant appears on the response channel in the cycle after acceptance.
- R6: An exclusive request from the line's current owner is answered with rsp_excl=1 and no forward, and the entry is unchanged.
- R7: An exclusive request to a line owned by another node produces no response. It sends one forward with fwd_kind=2 (transfer) to the owner, carrying the requester id, and the requester becomes the owner.
- R8: req_ready is 0 from acceptance until the transaction ends. At most one of rsp_valid, fwd_valid and wb_ready is high at a time. A raised rsp_valid or fwd_valid holds its payload stable until ready.
- R9: A read from the line's current owner is answered with the home data and rsp_excl=1, with no forward and no change to the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and accepting |
| req_node | input | NID_W | Requesting node |
| req_line | input | LINE_W | Requested line |
| req_excl | input | 1 | 1 = exclusive read, 0 = read |
| rsp_valid | output | 1 | Response to requester valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_node | output | NID_W | Destination node of the response |
| rsp_line | output | LINE_W | Line of the response |
| rsp_data | output | DATA_W | Home data of the line |
| rsp_excl | output | 1 | 1 = requester now owns the line |
| fwd_valid | output | 1 | Forward or invalidation valid |
| fwd_ready | input | 1 | Forward accepted |
| fwd_node | output | NID_W | Target node |
| fwd_line | output | LINE_W | Line concerned |
| fwd_kind | output | 2 | 0 read forward, 1 invalidate, 2 ownership transfer |
| fwd_req | output | NID_W | Requester the owner must answer |
| wb_valid | input | 1 | Write-back data offered by former owner |
| wb_ready | output | 1 | Controller awaiting write-back |
| wb_data | input | DATA_W | Write-back data |

## Verification
The bench builds the controller with four nodes, eight lines and 16-bit data. Four nodes allow a line to have up to three holders besides the requester, which exercises invalidation fan-out in ascending node order and the skipping of the requester inside a populated holder vector. Eight lines let one line move through every state transition while a second line starts from Invalid for the immediate-grant and owner-read cases, and an untouched third line shows the reset data. A stalled forward channel is used to show that the payload holds and that request acceptance stays closed.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    FK_READ  = 2'd0,
    FK_INVAL = 2'd1,
    FK_XFER  = 2'd2
  } fwd_kind_e;

  typedef enum logic [2:0] {
    C_IDLE,
    C_INV,
    C_FWD,
    C_WB,
    C_RSP
  } ctl_st_e;
endpackage

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int LINES  = 8,
  parameter int DATA_W = 16,
  localparam int NID_W  = $clog2(NODES),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] rd_line,
  output line_st_e          rd_st,
  output logic [NODES-1:0]  rd_shr,
  output logic [NID_W-1:0]  rd_own,
  input  logic              dir_we,
  input  logic [LINE_W-1:0] wr_line,
  input  line_st_e          wr_st,
  input  logic [NODES-1:0]  wr_shr,
  input  logic [NID_W-1:0]  wr_own,
  input  logic [LINE_W-1:0] dat_line,
  output logic [DATA_W-1:0] dat_out,
  input  logic              mem_we,
  input  logic [DATA_W-1:0] mem_data
);
  line_st_e          st_q  [LINES];
  logic [NODES-1:0]  shr_q [LINES];
  logic [NID_W-1:0]  own_q [LINES];
  logic [DATA_W-1:0] mem_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LS_INV;
        shr_q[i] <= '0;
        own_q[i] <= '0;
        mem_q[i] <= '0;
      end
    end else begin
      if (dir_we) begin
        st_q[wr_line]  <= wr_st;
        shr_q[wr_line] <= wr_shr;
        own_q[wr_line] <= wr_own;
      end
      if (mem_we) mem_q[dat_line] <= mem_data;
    end
  end

  assign rd_st   = st_q[rd_line];
  assign rd_shr  = shr_q[rd_line];
  assign rd_own  = own_q[rd_line];
  assign dat_out = mem_q[dat_line];
endmodule

// File: rtl/dir_pick.sv
module dir_pick #(
  parameter int NODES = 4,
  localparam int NID_W = $clog2(NODES)
) (
  input  logic [NODES-1:0] mask,
  output logic [NID_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (mask[i]) idx = NID_W'(i);
    end
  end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int LINES  = 8,
  parameter int DATA_W = 16,
  localparam int NID_W  = $clog2(NODES),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [NID_W-1:0]  req_node,
  input  logic [LINE_W-1:0] req_line,
  input  logic              req_excl,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [NID_W-1:0]  rsp_node,
  output logic [LINE_W-1:0] rsp_line,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_excl,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [NID_W-1:0]  fwd_node,
  output logic [LINE_W-1:0] fwd_line,
  output logic [1:0]        fwd_kind,
  output logic [NID_W-1:0]  fwd_req,
  input  logic              wb_valid,
  output logic              wb_ready,
  input  logic [DATA_W-1:0] wb_data
);
  ctl_st_e           cs;
  logic [NID_W-1:0]  t_node, t_tgt;
  logic [LINE_W-1:0] t_line;
  logic              t_rexcl;
  fwd_kind_e         t_kind;
  logic [NODES-1:0]  pend;

  line_st_e          rd_st;
  logic [NODES-1:0]  rd_shr;
  logic [NID_W-1:0]  rd_own;
  logic [DATA_W-1:0] dat_out;
  logic [NID_W-1:0]  pick_idx;
  logic [NODES-1:0]  pick_bit, pend_left;

  logic              acc;
  logic [NODES-1:0]  req_bit, own_bit;
  logic              is_exc, own_req;
  ctl_st_e           a_go;
  logic              a_we, a_rexcl;
  line_st_e          a_st;
  logic [NODES-1:0]  a_shr, a_pend;
  logic [NID_W-1:0]  a_own;
  fwd_kind_e         a_kind;

  dir_store #(.NODES(NODES), .LINES(LINES), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_line (req_line),
    .rd_st   (rd_st),
    .rd_shr  (rd_shr),
    .rd_own  (rd_own),
    .dir_we  (a_we),
    .wr_line (req_line),
    .wr_st   (a_st),
    .wr_shr  (a_shr),
    .wr_own  (a_own),
    .dat_line(t_line),
    .dat_out (dat_out),
    .mem_we  (cs == C_WB && wb_valid),
    .mem_data(wb_data)
  );

  dir_pick #(.NODES(NODES)) u_pick (
    .mask(pend),
    .idx (pick_idx)
  );

  assign pick_bit  = NODES'(1) << pick_idx;
  assign pend_left = pend & ~pick_bit;

  assign acc     = req_valid && (cs == C_IDLE);
  assign req_bit = NODES'(1) << req_node;
  assign own_bit = NODES'(1) << rd_own;
  assign is_exc  = (rd_st == LS_EXC);
  assign own_req = (rd_own == req_node);

  // Decision taken at acceptance; directory entry updated in the same cycle.
  always_comb begin
    a_go    = C_RSP;
    a_we    = 1'b0;
    a_st    = rd_st;
    a_shr   = rd_shr;
    a_own   = rd_own;
    a_pend  = '0;
    a_rexcl = 1'b0;
    a_kind  = FK_READ;
    if (acc) begin
      if (!req_excl) begin
        if (is_exc && !own_req) begin
          a_go  = C_FWD;
          a_we  = 1'b1;
          a_st  = LS_SHR;
          a_shr = own_bit | req_bit;
        end else if (is_exc) begin
          a_rexcl = 1'b1;
        end else begin
          a_we  = 1'b1;
          a_st  = LS_SHR;
          a_shr = rd_shr | req_bit;
        end
      end else begin
        a_rexcl = 1'b1;
        if (!(is_exc && own_req)) begin
          a_we  = 1'b1;
          a_st  = LS_EXC;
          a_shr = req_bit;
          a_own = req_node;
          if (is_exc) begin
            a_go   = C_FWD;
            a_kind = FK_XFER;
          end else begin
            a_pend = rd_shr & ~req_bit;
            a_go   = (a_pend != '0) ? C_INV : C_RSP;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs      <= C_IDLE;
      t_node  <= '0;
      t_tgt   <= '0;
      t_line  <= '0;
      t_rexcl <= 1'b0;
      t_kind  <= FK_READ;
      pend    <= '0;
    end else begin
      case (cs)
        C_IDLE: if (acc) begin
          t_node  <= req_node;
          t_line  <= req_line;
          t_tgt   <= rd_own;
          t_rexcl <= a_rexcl;
          t_kind  <= a_kind;
          pend    <= a_pend;
          cs      <= a_go;
        end
        C_INV: if (fwd_ready) begin
          pend <= pend_left;
          if (pend_left == '0) cs <= C_RSP;
        end
        C_FWD: if (fwd_ready) cs <= (t_kind == FK_READ) ? C_WB : C_IDLE;
        C_WB:  if (wb_valid) cs <= C_IDLE;
        C_RSP: if (rsp_ready) cs <= C_IDLE;
        default: cs <= C_IDLE;
      endcase
    end
  end

  assign req_ready = (cs == C_IDLE);
  assign rsp_valid = (cs == C_RSP);
  assign rsp_node  = t_node;
  assign rsp_line  = t_line;
  assign rsp_data  = dat_out;
  assign rsp_excl  = t_rexcl;
  assign fwd_valid = (cs == C_INV) || (cs == C_FWD);
  assign fwd_node  = (cs == C_INV) ? pick_idx : t_tgt;
  assign fwd_kind  = (cs == C_INV) ? FK_INVAL : t_kind;
  assign fwd_line  = t_line;
  assign fwd_req   = t_node;
  assign wb_ready  = (cs == C_WB);
endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int NODES  = 4,
  parameter int LINES  = 8,
  parameter int DATA_W = 16,
  localparam int NID_W  = $clog2(NODES),
  localparam int LINE_W = $clog2(LINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [NID_W-1:0]  req_node,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [NID_W-1:0]  rsp_node,
  input logic [LINE_W-1:0] rsp_line,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_excl,
  input logic              fwd_valid,
  input logic              fwd_ready,
  input logic [NID_W-1:0]  fwd_node,
  input logic [LINE_W-1:0] fwd_line,
  input logic [1:0]        fwd_kind,
  input logic [NID_W-1:0]  fwd_req,
  input logic              wb_ready
);
  logic [NID_W-1:0] cur_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_req <= '0;
    else if (req_valid && req_ready) cur_req <= req_node;
  end

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || fwd_valid || wb_ready) |-> !req_ready); // R8

  AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, fwd_valid, wb_ready})); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable({rsp_node, rsp_line, rsp_data, rsp_excl}))); // R8

  AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable({fwd_node, fwd_line, fwd_kind, fwd_req}))); // R8

  AST_FWD_NOT_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_node != cur_req)); // R5

  AST_WB_AFTER_READ_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_ready) |-> $past(fwd_valid && fwd_ready && fwd_kind == 2'd0)); // R3
endmodule

bind dir_home_ctrl dir_home_chk #(.NODES(NODES), .LINES(LINES), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_node (req_node),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_node (rsp_node),
  .rsp_line (rsp_line),
  .rsp_data (rsp_data),
  .rsp_excl (rsp_excl),
  .fwd_valid(fwd_valid),
  .fwd_ready(fwd_ready),
  .fwd_node (fwd_node),
  .fwd_line (fwd_line),
  .fwd_kind (fwd_kind),
  .fwd_req  (fwd_req),
  .wb_ready (wb_ready)
);

// File: tb/dir_home_ctrl_bench.sv
module dir_home_ctrl_bench;
  localparam int NODES = 4, LINES = 8, DATA_W = 16;
  localparam int NID_W = $clog2(NODES), LINE_W = $clog2(LINES);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_excl = 1'b0;
  logic [NID_W-1:0] req_node = '0;
  logic [LINE_W-1:0] req_line = '0;
  logic req_ready, rsp_valid, rsp_excl, fwd_valid, wb_ready;
  logic rsp_ready = 1'b1, fwd_ready = 1'b1, wb_valid = 1'b0;
  logic [NID_W-1:0] rsp_node, fwd_node, fwd_req;
  logic [LINE_W-1:0] rsp_line, fwd_line;
  logic [DATA_W-1:0] rsp_data, wb_data = '0;
  logic [1:0] fwd_kind;

  always #10 clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .LINES(LINES), .DATA_W(DATA_W)) u_dir_home_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_node(req_node),
    .req_line(req_line), .req_excl(req_excl),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_node(rsp_node),
    .rsp_line(rsp_line), .rsp_data(rsp_data), .rsp_excl(rsp_excl),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_node(fwd_node),
    .fwd_line(fwd_line), .fwd_kind(fwd_kind), .fwd_req(fwd_req),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data)
  );

  typedef struct {
    int node; int line; int data; int excl; string tag;
  } rsp_item_t;
  typedef struct {
    int node; int line; int kind; int rq; string tag;
  } fwd_item_t;

  rsp_item_t exp_rsp[$];
  fwd_item_t exp_fwd[$];
  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic er(input int node, input int line, input int data, input int excl, input string tag);
    rsp_item_t it;
    it.node = node; it.line = line; it.data = data; it.excl = excl; it.tag = tag;
    exp_rsp.push_back(it);
  endtask

  task automatic ef(input int node, input int line, input int kind, input int rq, input string tag);
    fwd_item_t it;
    it.node = node; it.line = line; it.kind = kind; it.rq = rq; it.tag = tag;
    exp_fwd.push_back(it);
  endtask

  // Monitor: compares every completed transfer against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_rsp.size() == 0) chk(1'b0, "R2", "unexpected response node", int'(rsp_node), -1);
      else begin
        rsp_item_t e;
        e = exp_rsp.pop_front();
        chk(int'(rsp_node) == e.node, e.tag, "rsp_node", int'(rsp_node), e.node);
        chk(int'(rsp_line) == e.line, e.tag, "rsp_line", int'(rsp_line), e.line);
        chk(int'(rsp_data) == e.data, e.tag, "rsp_data", int'(rsp_data), e.data);
        chk(int'(rsp_excl) == e.excl, e.tag, "rsp_excl", int'(rsp_excl), e.excl);
      end
    end
    if (rst_n && fwd_valid && fwd_ready) begin
      if (exp_fwd.size() == 0) chk(1'b0, "R5", "unexpected forward node", int'(fwd_node), -1);
      else begin
        fwd_item_t f;
        f = exp_fwd.pop_front();
        chk(int'(fwd_node) == f.node, f.tag, "fwd_node", int'(fwd_node), f.node);
        chk(int'(fwd_line) == f.line, f.tag, "fwd_line", int'(fwd_line), f.line);
        chk(int'(fwd_kind) == f.kind, f.tag, "fwd_kind", int'(fwd_kind), f.kind);
        if (f.kind != 1) chk(int'(fwd_req) == f.rq, f.tag, "fwd_req", int'(fwd_req), f.rq);
      end
    end
  end

  task automatic send(input int node, input int line, input bit excl);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_node = NID_W'(node); req_line = LINE_W'(line); req_excl = excl;
    req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic give_wb(input int data);
    @(negedge clk);
    while (!wb_ready) @(negedge clk);
    chk(req_ready == 1'b0, "R8", "req_ready while awaiting write-back", int'(req_ready), 0);
    wb_data = DATA_W'(data);
    wb_valid = 1'b1;
    @(posedge clk);
    #1 wb_valid = 1'b0;
  endtask

  task automatic finish_txn(input string tag);
    @(negedge clk);
    while (!req_ready || wb_ready || exp_rsp.size() != 0 || exp_fwd.size() != 0) @(negedge clk);
    chk(!rsp_valid && !fwd_valid, tag, "idle outputs", int'({rsp_valid, fwd_valid}), 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
    chk(fwd_valid == 1'b0, "R1", "fwd_valid", int'(fwd_valid), 0);
    chk(wb_ready == 1'b0, "R1", "wb_ready", int'(wb_ready), 0);

    // R1: untouched line reads zero; R2 read of Invalid line
    er(0, 7, 0, 0, "R1"); send(0, 7, 0); finish_txn("R1");
    er(1, 3, 0, 0, "R2"); send(1, 3, 0); finish_txn("R2");
    er(2, 3, 0, 0, "R2"); send(2, 3, 0); finish_txn("R2");

    // R4/R5: holders {1,2}, requester 2 -> only node 1 invalidated
    ef(1, 3, 1, 2, "R5"); er(2, 3, 0, 1, "R4"); send(2, 3, 1); finish_txn("R4");

    // R6: owner asks again
    er(2, 3, 0, 1, "R6"); send(2, 3, 1); finish_txn("R6");

    // R3: read forwarded to owner 2, write-back updates home data
    ef(2, 3, 0, 0, "R3"); send(0, 3, 0); give_wb(16'hBEEF); finish_txn("R3");
    er(3, 3, 16'hBEEF, 0, "R3"); send(3, 3, 0); finish_txn("R3");

    // R4: holders {0,2,3}, requester 0 -> invalidate 2 then 3
    ef(2, 3, 1, 0, "R4"); ef(3, 3, 1, 0, "R4"); er(0, 3, 16'hBEEF, 1, "R4");
    send(0, 3, 1); finish_txn("R4");

    // R7: ownership transfer from 0 to 1, then a read is forwarded to 1
    ef(0, 3, 2, 1, "R7"); send(1, 3, 1); finish_txn("R7");
    ef(1, 3, 0, 2, "R7"); send(2, 3, 0); give_wb(16'h1234); finish_txn("R7");

    // R5: exclusive on Invalid line, grant in the cycle after acceptance
    er(3, 5, 0, 1, "R5"); send(3, 5, 1);
    @(negedge clk);
    chk(rsp_valid && !fwd_valid, "R5", "immediate grant", int'({rsp_valid, fwd_valid}), 2);
    finish_txn("R5");

    // R9: owner read; R6 entry unchanged so next read forwards to 3
    er(3, 5, 0, 1, "R9"); send(3, 5, 0); finish_txn("R9");
    ef(3, 5, 0, 1, "R9"); send(1, 5, 0); give_wb(16'h00A5); finish_txn("R9");

    // R8: stalled forward channel, holders {1,3}, requester 0
    fwd_ready = 1'b0;
    ef(1, 5, 1, 0, "R8"); ef(3, 5, 1, 0, "R8"); er(0, 5, 16'h00A5, 1, "R8");
    send(0, 5, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(fwd_valid == 1'b1, "R8", "fwd_valid held", int'(fwd_valid), 1);
      chk(int'(fwd_node) == 1 && fwd_kind == 2'd1, "R8", "fwd payload held",
          int'({fwd_node, fwd_kind}), 5);
      chk(req_ready == 1'b0, "R8", "req_ready while busy", int'(req_ready), 0);
    end
    @(posedge clk);
    #1 fwd_ready = 1'b1;
    finish_txn("R8");

    summary();
    $finish;
  end
endmodule